// File: doc/BRIEF.md
# Flash Write-Gating and Command Unlock Controller

This block sits between the asynchronous bus pins of a 256K x16 parallel NOR flash and its array controller. It samples chip-enable, output-enable and write-enable through synchronizers on a free-running clock. Only strobes that are long enough and free of inhibit conditions become bus write cycles. These cycles feed an always-on command decoder. The decoder recognises a multi-step unlock sequence for word program and a longer one for erase.

A decoded request is checked against the boot-block window before it is raised. The window is either the lowest or the highest 8K words, chosen by a parameter, and it is protected while the write-protect pin is low. A separate reset pin, held low long enough, clears the decoder and drops any pending command. It pulses an abort if the array controller reports an operation in progress. It also lowers the read-ready indication for a recovery window after the pin is released.

Top module: `flash_wp_ctrl`

## Requirements
- R1: A bus write is taken only when the synchronized strobes show chip-enable low, write-enable low and output-enable high. The write commits when that condition ends, and only if output-enable is still high at that point. A strobe with output-enable low or chip-enable high is ignored and leaves the decoder state unchanged.
- R2: A strobe that is active for fewer than GLITCH_CYC sampled cycles (default 2) is ignored and leaves the decoder state unchanged.
- R3: A strobe during which vdd_low_i is high is ignored and leaves the decoder state unchanged.
- R4: Data bits [7:0] are compared, and address bits [10:0] are compared. The program sequence is AAh at 555h, then 55h at 2AAh, then A0h at 555h. The next write then raises prog_req_o for one cycle, with prog_addr_o and prog_data_o equal to that write's address and data.
- R5: The erase sequence is AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, followed by one of three final writes. 10h@555h requests chip erase (erase_kind_o=0, erase_addr_o=0). 30h at any address requests a 4K-word sector erase (kind 1). 50h at any address requests a 32K-word block erase (kind 2). Sector and block erase report the full write address on erase_addr_o.
- R6: Any write that does not match the next expected step returns the decoder to idle with no request. Every program or erase always requires the full sequence.
- R7: When wp_ni is low, two things are blocked. A program whose address lies in the boot window is blocked. An erase whose region overlaps the boot window is blocked, and chip erase always overlaps it. The window is 00000h–01FFFh for TOP_BOOT=0 and 3E000h–3FFFFh for TOP_BOOT=1.
- R8: hw_rst_ni held low for at least RST_MIN_CYC sampled cycles (default 3) has three effects. It clears the decoder so a pending command is dropped. It drives read_ready_o low. It pulses abort_o if busy_i is high. A shorter low pulse has no effect.
- R9: After a valid reset is released, read_ready_o stays low for at least RECOV_CYC cycles (default 4). It returns high within RECOV_CYC+SYNC_STAGES+3 cycles.
- R10: prog_req_o and erase_req_o are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| hw_rst_ni | input | 1 | Active-low device reset pin |
| ce_ni | input | 1 | Active-low chip enable strobe |
| oe_ni | input | 1 | Active-low output enable strobe |
| we_ni | input | 1 | Active-low write enable strobe |
| wp_ni | input | 1 | Active-low boot-block write protect |
| vdd_low_i | input | 1 | Supply below write threshold |
| busy_i | input | 1 | Array controller has an operation running |
| addr_i | input | 18 | Word address |
| data_i | input | 16 | Write data |
| prog_req_o | output | 1 | Word program request pulse |
| prog_addr_o | output | 18 | Program target address |
| prog_data_o | output | 16 | Program data |
| erase_req_o | output | 1 | Erase request pulse |
| erase_kind_o | output | 2 | 0 chip, 1 sector, 2 block |
| erase_addr_o | output | 18 | Erase target address |
| abort_o | output | 1 | Pulse: running operation aborted by reset |
| read_ready_o | output | 1 | Array readable |

## Verification
A decoder left in the wrong state shows up on the very next sequence. It appears as a missing request, or as an unexpected request on a write that should have been a plain target, within about ten sampling cycles of that bus write. Each stimulus that should be ignored is therefore followed by a legal write whose outcome depends on the decoder state. A wrong boot-window or overlap computation appears as a request present or absent for a specific address and write-protect level; the program and erase sweeps cover both sides of every window edge. A stuck reset or recovery counter shows as read_ready_o at the wrong level a few cycles after the pin is released.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  typedef enum logic [1:0] {
    ERS_CHIP   = 2'd0,
    ERS_SECTOR = 2'd1,
    ERS_BLOCK  = 2'd2
  } erase_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_ERS1,
    ST_ERS2,
    ST_ERS3
  } cmd_state_e;

  localparam int unsigned CMD_AW = 11;
  localparam logic [CMD_AW-1:0] ADR_KEY1 = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_KEY2 = 11'h2AA;
  localparam logic [7:0] OP_KEY1   = 8'hAA;
  localparam logic [7:0] OP_KEY2   = 8'h55;
  localparam logic [7:0] OP_PROG   = 8'hA0;
  localparam logic [7:0] OP_ERASE  = 8'h80;
  localparam logic [7:0] OP_CHIP   = 8'h10;
  localparam logic [7:0] OP_SECTOR = 8'h30;
  localparam logic [7:0] OP_BLOCK  = 8'h50;
endpackage

// File: rtl/flash_wp_sync.sv
module flash_wp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/flash_wp_strobe.sv
module flash_wp_strobe #(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned GLITCH_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_s_i,
  input  logic              oe_s_i,
  input  logic              we_s_i,
  input  logic              hwrst_s_i,
  input  logic              vdd_low_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned GW = $clog2(GLITCH_CYC + 1);
  localparam logic [GW-1:0] GMAX = GW'(GLITCH_CYC);

  logic          active;
  logic          strobe_end;
  logic          armed;
  logic [GW-1:0] len_q;
  logic          taint_q;

  assign active     = !ce_s_i && !we_s_i && oe_s_i;
  assign strobe_end = !active && (len_q != '0);
  assign armed      = (len_q == GMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q     <= '0;
      taint_q   <= 1'b0;
      wr_o      <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_o <= strobe_end && armed && !taint_q && oe_s_i && hwrst_s_i && !vdd_low_i;
      if (active) begin
        if (len_q != GMAX) len_q <= len_q + 1'b1;
        if (vdd_low_i || !hwrst_s_i) taint_q <= 1'b1;
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
      end else begin
        len_q   <= '0;
        taint_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard #(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned BOOT_W   = 13,
  parameter int unsigned SECTOR_W = 12,
  parameter int unsigned BLOCK_W  = 15,
  parameter bit          TOP_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_ni,
  output logic              prog_ok_o,
  output logic              sector_ok_o,
  output logic              block_ok_o,
  output logic              chip_ok_o
);
  localparam logic [ADDR_W-1:0] BOOT_MASK   = ADDR_W'({BOOT_W{1'b1}});
  localparam logic [ADDR_W-1:0] SECTOR_MASK = ADDR_W'({SECTOR_W{1'b1}});
  localparam logic [ADDR_W-1:0] BLOCK_MASK  = ADDR_W'({BLOCK_W{1'b1}});

  logic [ADDR_W-1:0] boot_lo, boot_hi;

  generate
    if (TOP_BOOT) begin : g_top
      assign boot_lo = ~BOOT_MASK;
      assign boot_hi = '1;
    end else begin : g_bottom
      assign boot_lo = '0;
      assign boot_hi = BOOT_MASK;
    end
  endgenerate

  logic in_boot, sector_hit, block_hit;

  always_comb begin
    in_boot    = (addr_i >= boot_lo) && (addr_i <= boot_hi);
    sector_hit = ((addr_i & ~SECTOR_MASK) <= boot_hi) && ((addr_i | SECTOR_MASK) >= boot_lo);
    block_hit  = ((addr_i & ~BLOCK_MASK) <= boot_hi) && ((addr_i | BLOCK_MASK) >= boot_lo);
  end

  assign prog_ok_o   = wp_ni || !in_boot;
  assign sector_ok_o = wp_ni || !sector_hit;
  assign block_ok_o  = wp_ni || !block_hit;
  assign chip_ok_o   = wp_ni;
endmodule

// File: rtl/flash_wp_cmd.sv
module flash_wp_cmd
  import flash_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              prog_ok_i,
  input  logic              sector_ok_i,
  input  logic              block_ok_i,
  input  logic              chip_ok_i,
  output logic              prog_req_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              erase_req_o,
  output logic [1:0]        erase_kind_o,
  output logic [ADDR_W-1:0] erase_addr_o
);
  cmd_state_e state_q;

  logic [7:0]        op;
  logic [CMD_AW-1:0] ca;
  logic key1, key2;

  assign op   = data_i[7:0];
  assign ca   = addr_i[CMD_AW-1:0];
  assign key1 = (op == OP_KEY1) && (ca == ADR_KEY1);
  assign key2 = (op == OP_KEY2) && (ca == ADR_KEY2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      prog_req_o   <= 1'b0;
      prog_addr_o  <= '0;
      prog_data_o  <= '0;
      erase_req_o  <= 1'b0;
      erase_kind_o <= ERS_CHIP;
      erase_addr_o <= '0;
    end else begin
      prog_req_o  <= 1'b0;
      erase_req_o <= 1'b0;
      if (clear_i) begin
        state_q <= ST_IDLE;
      end else if (wr_i) begin
        state_q <= ST_IDLE;
        unique case (state_q)
          ST_IDLE: if (key1) state_q <= ST_UNL1;
          ST_UNL1: if (key2) state_q <= ST_UNL2;
          ST_UNL2: begin
            if (ca == ADR_KEY1 && op == OP_PROG)       state_q <= ST_PROG;
            else if (ca == ADR_KEY1 && op == OP_ERASE) state_q <= ST_ERS1;
          end
          ST_PROG: begin
            prog_req_o  <= prog_ok_i;
            prog_addr_o <= addr_i;
            prog_data_o <= data_i;
          end
          ST_ERS1: if (key1) state_q <= ST_ERS2;
          ST_ERS2: if (key2) state_q <= ST_ERS3;
          ST_ERS3: begin
            if (ca == ADR_KEY1 && op == OP_CHIP) begin
              erase_req_o  <= chip_ok_i;
              erase_kind_o <= ERS_CHIP;
              erase_addr_o <= '0;
            end else if (op == OP_SECTOR) begin
              erase_req_o  <= sector_ok_i;
              erase_kind_o <= ERS_SECTOR;
              erase_addr_o <= addr_i;
            end else if (op == OP_BLOCK) begin
              erase_req_o  <= block_ok_i;
              erase_kind_o <= ERS_BLOCK;
              erase_addr_o <= addr_i;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_wp_rstctl.sv
module flash_wp_rstctl #(
  parameter int unsigned RST_MIN_CYC = 3,
  parameter int unsigned RECOV_CYC   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hwrst_s_i,
  input  logic busy_i,
  output logic clear_o,
  output logic abort_o,
  output logic read_ready_o
);
  localparam int unsigned RW = $clog2(RST_MIN_CYC + 1);
  localparam int unsigned CW = $clog2(RECOV_CYC + 1);
  localparam logic [RW-1:0] RMAX = RW'(RST_MIN_CYC);
  localparam logic [CW-1:0] CMAX = CW'(RECOV_CYC);

  logic [RW-1:0] low_q;
  logic [CW-1:0] rec_q;
  logic          held;
  logic          hit;

  assign held    = (low_q == RMAX);
  assign hit     = !hwrst_s_i && (low_q == RMAX - 1'b1);
  assign clear_o = held || hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q        <= '0;
      rec_q        <= '0;
      abort_o      <= 1'b0;
      read_ready_o <= 1'b1;
    end else begin
      abort_o <= hit && busy_i;
      if (!hwrst_s_i) begin
        if (low_q != RMAX) low_q <= low_q + 1'b1;
      end else begin
        low_q <= '0;
      end
      if (clear_o) begin
        read_ready_o <= 1'b0;
        rec_q        <= CMAX;
      end else if (!read_ready_o) begin
        if (rec_q == '0) read_ready_o <= 1'b1;
        else             rec_q <= rec_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned BOOT_W      = 13,
  parameter int unsigned SECTOR_W    = 12,
  parameter int unsigned BLOCK_W     = 15,
  parameter bit          TOP_BOOT    = 1'b0,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GLITCH_CYC  = 2,
  parameter int unsigned RST_MIN_CYC = 3,
  parameter int unsigned RECOV_CYC   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              wp_ni,
  input  logic              vdd_low_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              prog_req_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              erase_req_o,
  output logic [1:0]        erase_kind_o,
  output logic [ADDR_W-1:0] erase_addr_o,
  output logic              abort_o,
  output logic              read_ready_o
);
  logic [3:0] pins_s;
  logic hwrst_s, ce_s, oe_s, we_s;

  flash_wp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hw_rst_ni, ce_ni, oe_ni, we_ni}),
    .q_o   (pins_s)
  );
  assign {hwrst_s, ce_s, oe_s, we_s} = pins_s;

  logic              wr;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  flash_wp_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC)) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_s_i   (ce_s),
    .oe_s_i   (oe_s),
    .we_s_i   (we_s),
    .hwrst_s_i(hwrst_s),
    .vdd_low_i(vdd_low_i),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .wr_o     (wr),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  logic prog_ok, sector_ok, block_ok, chip_ok;

  flash_wp_guard #(
    .ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .SECTOR_W(SECTOR_W),
    .BLOCK_W(BLOCK_W), .TOP_BOOT(TOP_BOOT)
  ) u_guard (
    .addr_i     (wr_addr),
    .wp_ni      (wp_ni),
    .prog_ok_o  (prog_ok),
    .sector_ok_o(sector_ok),
    .block_ok_o (block_ok),
    .chip_ok_o  (chip_ok)
  );

  logic clear;

  flash_wp_rstctl #(.RST_MIN_CYC(RST_MIN_CYC), .RECOV_CYC(RECOV_CYC)) u_rstctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hwrst_s_i   (hwrst_s),
    .busy_i      (busy_i),
    .clear_o     (clear),
    .abort_o     (abort_o),
    .read_ready_o(read_ready_o)
  );

  flash_wp_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .wr_i        (wr),
    .addr_i      (wr_addr),
    .data_i      (wr_data),
    .prog_ok_i   (prog_ok),
    .sector_ok_i (sector_ok),
    .block_ok_i  (block_ok),
    .chip_ok_i   (chip_ok),
    .prog_req_o  (prog_req_o),
    .prog_addr_o (prog_addr_o),
    .prog_data_o (prog_data_o),
    .erase_req_o (erase_req_o),
    .erase_kind_o(erase_kind_o),
    .erase_addr_o(erase_addr_o)
  );
endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk #(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned BOOT_W   = 13,
  parameter bit          TOP_BOOT = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hw_rst_ni,
  input logic              wp_ni,
  input logic              prog_req_o,
  input logic [ADDR_W-1:0] prog_addr_o,
  input logic              erase_req_o,
  input logic [1:0]        erase_kind_o,
  input logic              abort_o,
  input logic              read_ready_o
);
  localparam logic [ADDR_W-1:0] BMASK = ADDR_W'({BOOT_W{1'b1}});

  logic prog_in_boot;
  assign prog_in_boot = TOP_BOOT ? ((prog_addr_o & ~BMASK) == ~BMASK)
                                 : ((prog_addr_o & ~BMASK) == '0);

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_req_o && erase_req_o));
  a_r10_prog_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |=> !prog_req_o);
  a_r10_erase_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |=> !erase_req_o);
  a_r7_boot_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o && prog_in_boot) |-> $past(wp_ni));
  a_r7_chip_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_req_o && erase_kind_o == 2'd0) |-> $past(wp_ni));
  a_r8_abort_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !read_ready_o);
  a_r9_ready_pin_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(read_ready_o) |-> hw_rst_ni);
endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk #(
  .ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .TOP_BOOT(TOP_BOOT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hw_rst_ni   (hw_rst_ni),
  .wp_ni       (wp_ni),
  .prog_req_o  (prog_req_o),
  .prog_addr_o (prog_addr_o),
  .erase_req_o (erase_req_o),
  .erase_kind_o(erase_kind_o),
  .abort_o     (abort_o),
  .read_ready_o(read_ready_o)
);

// File: tb/flash_wp_ctrl_test.sv
module flash_wp_ctrl_test;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam int BOOT_LO = 0;
  localparam int BOOT_HI = 'h1FFF;
  localparam int RECOV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_rst_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic wp_n = 1'b1, vdd_low = 1'b0, busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic prog_req, erase_req, abort, ready;
  logic [AW-1:0] prog_addr, erase_addr;
  logic [DW-1:0] prog_data;
  logic [1:0] erase_kind;

  always #5 clk = ~clk;

  flash_wp_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .hw_rst_ni(hw_rst_n), .ce_ni(ce_n), .oe_ni(oe_n),
    .we_ni(we_n), .wp_ni(wp_n), .vdd_low_i(vdd_low), .busy_i(busy), .addr_i(addr),
    .data_i(data), .prog_req_o(prog_req), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
    .erase_req_o(erase_req), .erase_kind_o(erase_kind), .erase_addr_o(erase_addr),
    .abort_o(abort), .read_ready_o(ready)
  );

  int n_tests = 0, n_fail = 0;
  int prog_cnt = 0, erase_cnt = 0, abort_cnt = 0;
  logic [AW-1:0] last_paddr, last_eaddr;
  logic [DW-1:0] last_pdata;
  logic [1:0] last_kind;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (prog_req) begin prog_cnt++; last_paddr = prog_addr; last_pdata = prog_data; end
    if (erase_req) begin erase_cnt++; last_eaddr = erase_addr; last_kind = erase_kind; end
    if (abort) abort_cnt++;
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(int a, int d, int len = 3, bit oe_lo = 0, bit ce_hi = 0, bit vlow = 0);
    @(negedge clk);
    addr = AW'(a); data = DW'(d);
    oe_n = !oe_lo; ce_n = ce_hi; we_n = 1'b0; vdd_low = vlow;
    repeat (len) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (6) @(negedge clk);
    vdd_low = 1'b0;
  endtask

  task automatic prog_head();
    bus_wr('h555, 'hAA); bus_wr('h2AA, 'h55); bus_wr('h555, 'hA0);
  endtask

  task automatic erase_head();
    bus_wr('h555, 'hAA); bus_wr('h2AA, 'h55); bus_wr('h555, 'h80);
    bus_wr('h555, 'hAA); bus_wr('h2AA, 'h55);
  endtask

  function automatic bit overlap(int a, int size);
    int base = a & ~(size - 1);
    return (base <= BOOT_HI) && (base + size - 1 >= BOOT_LO);
  endfunction

  task automatic do_prog(string req, int a, int d, bit exp_issue);
    int c0 = prog_cnt;
    prog_head();
    bus_wr(a, d);
    chk(prog_cnt - c0 == int'(exp_issue), req, "program count", prog_cnt - c0, exp_issue);
    if (exp_issue && prog_cnt - c0 == 1) begin
      chk(last_paddr == AW'(a), req, "program addr", last_paddr, a);
      chk(last_pdata == DW'(d), req, "program data", last_pdata, d);
    end
  endtask

  task automatic do_erase(string req, int a, int op, bit exp_issue, int kind, int eaddr);
    int c0 = erase_cnt;
    erase_head();
    bus_wr(a, op);
    chk(erase_cnt - c0 == int'(exp_issue), req, "erase count", erase_cnt - c0, exp_issue);
    if (exp_issue && erase_cnt - c0 == 1) begin
      chk(last_kind == 2'(kind), req, "erase kind", last_kind, kind);
      chk(last_eaddr == AW'(eaddr), req, "erase addr", last_eaddr, eaddr);
    end
  endtask

  task automatic pulse_hw_rst(int cycles);
    @(negedge clk); hw_rst_n = 1'b0;
    repeat (cycles) @(negedge clk);
    hw_rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10, R9: idle state after reset
    chk(!prog_req && !erase_req, "R10", "reset requests", {prog_req, erase_req}, 0);
    chk(ready == 1'b1, "R9", "reset read_ready", ready, 1);

    // R4: basic program
    do_prog("R4", 'h12345, 'hBEEF, 1'b1);

    // R4, R7: sweep of targets across window edges, both protect levels
    for (int wp = 0; wp < 2; wp++) begin
      for (int i = 0; i < 12; i++) begin
        int a;
        case (i)
          0: a = 0; 1: a = 'h1FFF; 2: a = 'h2000; 3: a = 'h3DFFF;
          4: a = 'h3E000; 5: a = 'h3FFFF; 6: a = 'h1000; 7: a = 'h0555;
          default: a = (i * 'h4321 + wp * 'h777) & 'h3FFFF;
        endcase
        wp_n = wp[0];
        do_prog("R7", a, (i * 'h1111) ^ wp, wp[0] || !(a >= BOOT_LO && a <= BOOT_HI));
      end
    end
    wp_n = 1'b1;

    // R5, R7: erase kinds and window overlap
    for (int wp = 0; wp < 2; wp++) begin
      wp_n = wp[0];
      do_erase("R5", 'h555, 'h10, wp[0], 0, 0);
      for (int i = 0; i < 6; i++) begin
        int a;
        case (i)
          0: a = 'h00100; 1: a = 'h01000; 2: a = 'h02000;
          3: a = 'h08000; 4: a = 'h3F000; default: a = 'h3E000;
        endcase
        do_erase("R7", a, 'h30, wp[0] || !overlap(a, 'h1000), 1, a);
        do_erase("R7", a, 'h50, wp[0] || !overlap(a, 'h8000), 2, a);
      end
    end
    wp_n = 1'b1;

    // R6: mismatched steps return to idle
    for (int v = 0; v < 4; v++) begin
      c0 = prog_cnt;
      case (v)
        0: begin bus_wr('h555, 'hAB); bus_wr('h2AA, 'h55); bus_wr('h555, 'hA0); end
        1: begin bus_wr('h555, 'hAA); bus_wr('h2AB, 'h55); bus_wr('h555, 'hA0); end
        2: begin bus_wr('h555, 'hAA); bus_wr('h2AA, 'h55); bus_wr('h555, 'h90); end
        default: begin bus_wr('h555, 'hAA); bus_wr('h2AA, 'h55); bus_wr('h554, 'hA0); end
      endcase
      bus_wr('h00300, 'h1234);
      chk(prog_cnt == c0, "R6", "program after mismatch", prog_cnt - c0, 0);
    end
    c0 = erase_cnt;
    bus_wr('h555, 'hAA); bus_wr('h2AA, 'h55); bus_wr('h555, 'h80);
    bus_wr('h555, 'hAA); bus_wr('h2AA, 'h56); bus_wr('h555, 'h10);
    chk(erase_cnt == c0, "R6", "erase after mismatch", erase_cnt - c0, 0);
    c0 = prog_cnt;
    bus_wr('h00400, 'h5678);
    chk(prog_cnt == c0, "R6", "lone target write", prog_cnt - c0, 0);

    // R2: glitch strobes ignored, decoder keeps its state
    prog_head();
    c0 = prog_cnt;
    bus_wr('h00500, 'h1111, 1);
    chk(prog_cnt == c0, "R2", "glitch program", prog_cnt - c0, 0);
    bus_wr('h00600, 'h2222);
    chk(prog_cnt == c0 + 1 && last_paddr == AW'('h600), "R2", "program after glitch", last_paddr, 'h600);

    // R1: output-enable low and chip-enable high inhibit
    prog_head();
    c0 = prog_cnt;
    bus_wr('h00700, 'h3333, 3, 1'b1, 1'b0, 1'b0);
    chk(prog_cnt == c0, "R1", "oe low write", prog_cnt - c0, 0);
    bus_wr('h00710, 'h4444, 3, 1'b0, 1'b1, 1'b0);
    chk(prog_cnt == c0, "R1", "ce high write", prog_cnt - c0, 0);
    bus_wr('h00720, 'h5555);
    chk(last_paddr == AW'('h720) && prog_cnt == c0 + 1, "R1", "program after inhibit", last_paddr, 'h720);

    // R3: low supply inhibit
    prog_head();
    c0 = prog_cnt;
    bus_wr('h00800, 'h6666, 3, 1'b0, 1'b0, 1'b1);
    chk(prog_cnt == c0, "R3", "low supply write", prog_cnt - c0, 0);
    bus_wr('h00810, 'h7777);
    chk(last_pdata == DW'('h7777) && prog_cnt == c0 + 1, "R3", "program after low supply", last_pdata, 'h7777);

    // R8: short reset pulse has no effect
    bus_wr('h555, 'hAA); bus_wr('h2AA, 'h55);
    pulse_hw_rst(1);
    repeat (4) @(negedge clk);
    chk(ready == 1'b1, "R8", "ready after short pulse", ready, 1);
    c0 = prog_cnt;
    bus_wr('h555, 'hA0); bus_wr('h00900, 'h8888);
    chk(prog_cnt == c0 + 1, "R8", "program across short pulse", prog_cnt - c0, 1);

    // R8, R9: valid reset clears pending program, aborts busy op, recovery window
    prog_head();
    busy = 1'b1;
    c0 = abort_cnt;
    @(negedge clk); hw_rst_n = 1'b0;
    repeat (8) @(negedge clk);
    chk(ready == 1'b0, "R8", "ready during reset", ready, 0);
    chk(abort_cnt == c0 + 1, "R8", "abort pulses", abort_cnt - c0, 1);
    busy = 1'b0;
    hw_rst_n = 1'b1;
    repeat (RECOV) @(negedge clk);
    chk(ready == 1'b0, "R9", "ready in recovery", ready, 0);
    repeat (RECOV + 4) @(negedge clk);
    chk(ready == 1'b1, "R9", "ready after recovery", ready, 1);
    c0 = prog_cnt;
    bus_wr('h00A00, 'h9999);
    chk(prog_cnt == c0, "R8", "dropped program", prog_cnt - c0, 0);

    // R8: reset without busy gives no abort
    c0 = abort_cnt;
    pulse_hw_rst(8);
    repeat (16) @(negedge clk);
    chk(abort_cnt == c0, "R8", "no abort when idle", abort_cnt - c0, 0);
    do_prog("R4", 'h2A5A5, 'hC3C3, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule